// File: doc/BRIEF.md
# Dither Track/Hold Sequence Generator

This block is the digital timing core of a line-drop correction controller. It runs from the fast oscillator clock and splits time into repeating dither cycles. The cycle length is a power-of-two multiple of the oscillator period, chosen by a 3-bit ratio select. Each cycle has two halves. In the first half the external power stage regulates voltage. In the second half it regulates current at a reduced level. Near the end of each half the block raises track strobes, so that the analog hold stages sample only after the loop has settled.

The difference between the high and low voltage levels is captured on the last clock of a cycle and is applied as correction during the next cycle. The correction-enable flag therefore stays low for the whole first cycle after a start. A start happens when run goes high with no overvoltage present, and each start gives a one-clock soft-correct pulse. An overvoltage stops the sequence at once, and clearing it begins a fresh soft-correct start.

When spread is enabled, a pseudo-random value stretches the voltage half of each cycle by a few oscillator clocks. This breaks up beat tones with periodic loads. The oscillator clock is also passed straight out as a synchronisation output for the external regulator.

Top module: `dither_seq_gen`

## Requirements
- R1: With spread off, a cycle lasts N = 8·2^ratio_sel oscillator clocks (ratio_sel=0 gives 8, ratio_sel=7 gives 1024).
- R2: Each cycle starts with mode_cur low (voltage regulation) for the first N/2+J clocks, then mode_cur is high (current regulation) for the remaining N/2 clocks. J is the jitter from R6 and is 0 with spread off.
- R3: trk_vhi and trk_iout are high together during the last N/8 clocks of the voltage half, and low at all other times.
- R4: In the current half, trk_vlo is high for N/8 clocks ending one clock before the cycle end, and trk_dlt is high only on the last clock of the cycle. No two of trk_vhi, trk_vlo and trk_dlt are ever high together.
- R5: corr_en is low during the first cycle after a start. It rises on the clock after the first cycle ends and stays high until the sequence stops.
- R6: With spread_en high, J equals bits [1:0] of a 16-bit shift register. The register shifts toward the MSB, and the bit fed in is the XOR of bits 15, 13, 12 and 10. It is loaded with 16'hACE1 at every start and advances once at each cycle end. spread_en is sampled at each cycle start.
- R7: While run is low, all strobes, mode_cur, corr_en and ss_start are low, and cycle_cnt is 0. ratio_sel and spread_en have no effect during this time.
- R8: On the first clock after run is high and ovp is low, following a time when that was not the case, ss_start is high for exactly one clock and the cycle begins at its first clock.
- R9: On the clock after ovp is sampled high, mode_cur, all strobes and corr_en are low. They stay low while ovp remains high.
- R10: A change of ratio_sel during a cycle does not alter that cycle's length. The new value takes effect from the next cycle.
- R11: cycle_cnt counts the cycles completed since the last start.
- R12: sync_out follows the oscillator clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 3 | Ratio select, N = 8·2^ratio_sel |
| spread_en | input | 1 | Enables pseudo-random stretch of the voltage half |
| run | input | 1 | Supply-valid flag from the run comparator |
| ovp | input | 1 | Overvoltage flag |
| sync_out | output | 1 | Clock output for regulator synchronisation |
| mode_cur | output | 1 | 0 = voltage regulation, 1 = current regulation |
| trk_vhi | output | 1 | Track high voltage level |
| trk_iout | output | 1 | Track output current |
| trk_vlo | output | 1 | Track low voltage level |
| trk_dlt | output | 1 | Track voltage difference |
| corr_en | output | 1 | Held correction is valid and applied |
| ss_start | output | 1 | One-clock soft-correct start pulse |
| cycle_cnt | output | 16 | Completed cycles since start |

## Verification
Every ratio code from 0 to 7 is run with spread off. Measuring each cycle length separates a correct doubling table from an off-by-one or a wrong base. The smallest ratio is then stepped clock by clock, so the strobe windows and the mode switch are pinned to exact positions, and this is where an overlap or a shifted window shows up. Spread runs are compared cycle by cycle against a model of the shift register, which separates a correct jitter from a wrong seed, wrong taps or a wrong advance point. Mid-cycle ratio changes, overvoltage pulses and run drops show whether a change is latched at the cycle boundary and whether a restart brings back the soft-correct pulse and the blank first cycle.

// File: rtl/dither_pkg.sv
package dither_pkg;
  localparam int SEL_W    = 3;
  localparam int BASE_LOG = 3;
  localparam int JIT_W    = 2;
  localparam int LFSR_W   = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
  localparam int POS_W    = BASE_LOG + (1 << SEL_W);

  typedef logic [POS_W-1:0] pos_t;

  typedef struct packed {
    logic vhi;
    logic iout;
    logic vlo;
    logic dlt;
  } strobe_t;

  function automatic pos_t period_of(input logic [SEL_W-1:0] s);
    return pos_t'(1) << (BASE_LOG + int'(s));
  endfunction
endpackage

// File: rtl/dither_lfsr.sv
module dither_lfsr import dither_pkg::*; #(
  parameter int W = LFSR_W,
  parameter logic [W-1:0] SEED = LFSR_SEED,
  parameter logic [W-1:0] TAPS = LFSR_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [JIT_W-1:0] jit_q,
  output logic [JIT_W-1:0] jit_nx
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_nx;

  always_comb begin
    state_nx = {state_q[W-2:0], ^(state_q & TAPS)};
    jit_q    = state_q[JIT_W-1:0];
    jit_nx   = state_nx[JIT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= SEED;
    else if (load) state_q <= SEED;
    else if (step) state_q <= state_nx;
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) state_q != '0); // R6
endmodule

// File: rtl/dither_timebase.sv
module dither_timebase import dither_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             spread_en,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic [JIT_W-1:0] jit_now,
  input  logic [JIT_W-1:0] jit_next,
  output logic             active,
  output pos_t             pos,
  output pos_t             hv,
  output pos_t             h,
  output pos_t             q,
  output logic             cyc_end,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [SEL_W-1:0] sel_q;
  logic [JIT_W-1:0] j_q;
  pos_t             n, len, jx;

  always_comb begin
    n       = period_of(sel_q);
    h       = n >> 1;
    q       = n >> 3;
    jx      = pos_t'(j_q);
    hv      = h + jx;
    len     = n + jx;
    cyc_end = active && (pos == len - pos_t'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
      cnt    <= '0;
      sel_q  <= '0;
      j_q    <= '0;
    end else if (!go) begin
      active <= 1'b0;
      pos    <= '0;
      cnt    <= '0;
      sel_q  <= ratio_sel;
      j_q    <= '0;
    end else if (!active) begin
      active <= 1'b1;
      pos    <= '0;
      sel_q  <= ratio_sel;
      j_q    <= spread_en ? jit_now : '0;
    end else if (cyc_end) begin
      pos    <= '0;
      cnt    <= cnt + CNT_ONE;
      sel_q  <= ratio_sel;
      j_q    <= spread_en ? jit_next : '0;
    end else begin
      pos    <= pos + pos_t'(1);
    end
  end

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) active |-> pos < len); // R1
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n) (go && active && !cyc_end) |=> $stable(sel_q)); // R10
endmodule

// File: rtl/dither_phase_dec.sv
module dither_phase_dec import dither_pkg::*; (
  input  logic    active,
  input  pos_t    pos,
  input  pos_t    hv,
  input  pos_t    h,
  input  pos_t    q,
  output logic    mode_cur,
  output strobe_t stb
);
  logic in_cur;
  logic v_win;
  pos_t c;

  always_comb begin
    in_cur   = pos >= hv;
    c        = pos - hv;
    v_win    = active && !in_cur && (pos >= hv - q);
    mode_cur = active && in_cur;
    stb.vhi  = v_win;
    stb.iout = v_win;
    stb.vlo  = active && in_cur && (c >= h - q - pos_t'(1)) && (c <= h - pos_t'(2));
    stb.dlt  = active && in_cur && (c == h - pos_t'(1));
  end
endmodule

// File: rtl/dither_seq_gen.sv
module dither_seq_gen import dither_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             spread_en,
  input  logic             run,
  input  logic             ovp,
  output logic             sync_out,
  output logic             mode_cur,
  output logic             trk_vhi,
  output logic             trk_iout,
  output logic             trk_vlo,
  output logic             trk_dlt,
  output logic             corr_en,
  output logic             ss_start,
  output logic [CNT_W-1:0] cycle_cnt
);
  logic             go;
  logic             active, cyc_end;
  logic [JIT_W-1:0] jit_q, jit_nx;
  pos_t             pos, hv, h, q;
  strobe_t          stb;
  logic             ss_q, corr_q;

  assign go       = run & ~ovp;
  assign sync_out = clk;

  dither_lfsr u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (!go),
    .step   (go && cyc_end),
    .jit_q  (jit_q),
    .jit_nx (jit_nx)
  );

  dither_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .spread_en (spread_en),
    .ratio_sel (ratio_sel),
    .jit_now   (jit_q),
    .jit_next  (jit_nx),
    .active    (active),
    .pos       (pos),
    .hv        (hv),
    .h         (h),
    .q         (q),
    .cyc_end   (cyc_end),
    .cnt       (cycle_cnt)
  );

  dither_phase_dec u_dec (
    .active   (active),
    .pos      (pos),
    .hv       (hv),
    .h        (h),
    .q        (q),
    .mode_cur (mode_cur),
    .stb      (stb)
  );

  assign trk_vhi  = stb.vhi;
  assign trk_iout = stb.iout;
  assign trk_vlo  = stb.vlo;
  assign trk_dlt  = stb.dlt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q   <= 1'b0;
      corr_q <= 1'b0;
    end else begin
      ss_q <= go & ~active;
      if (!go)         corr_q <= 1'b0;
      else if (cyc_end) corr_q <= 1'b1;
    end
  end

  assign ss_start = ss_q;
  assign corr_en  = corr_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({trk_vhi, trk_vlo, trk_dlt})); // R4
  AST_DLT_THEN_VOLT: assert property (@(posedge clk) disable iff (!rst_n) trk_dlt |=> !mode_cur); // R2
  AST_SS_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) ss_start |=> !ss_start); // R8
  AST_CORR_OFF_AT_START: assert property (@(posedge clk) disable iff (!rst_n) ss_start |-> !corr_en); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !run |=> (!mode_cur && !trk_vhi && !trk_vlo && !trk_dlt && cycle_cnt == '0)); // R7
  AST_OVP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ovp |=> (!mode_cur && !corr_en && !trk_vhi)); // R9
endmodule

// File: tb/tb_dither_seq_gen.sv
`timescale 1ns/1ps
module tb_dither_seq_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ratio_sel = 3'd0;
  logic        spread_en = 1'b0;
  logic        run = 1'b0;
  logic        ovp = 1'b0;
  logic        sync_out, mode_cur, trk_vhi, trk_iout, trk_vlo, trk_dlt, corr_en, ss_start;
  logic [15:0] cycle_cnt;

  int n_checks = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  dither_seq_gen dut (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .spread_en(spread_en),
    .run(run), .ovp(ovp), .sync_out(sync_out), .mode_cur(mode_cur),
    .trk_vhi(trk_vhi), .trk_iout(trk_iout), .trk_vlo(trk_vlo), .trk_dlt(trk_dlt),
    .corr_en(corr_en), .ss_start(ss_start), .cycle_cnt(cycle_cnt)
  );

  // reference state built from the requirements
  bit          m_act, m_ss, m_corr;
  int          m_pos, m_j;
  logic [2:0]  m_sel;
  logic [15:0] m_cnt, m_lfsr;

  function automatic logic [15:0] adv(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_next();
    int n;
    n = 8 << m_sel;
    if (!rst_n || !(run && !ovp)) begin
      m_act = 0; m_pos = 0; m_cnt = 0; m_lfsr = 16'hACE1; m_j = 0; m_ss = 0; m_corr = 0;
      m_sel = rst_n ? ratio_sel : 3'd0;
    end else if (!m_act) begin
      m_act = 1; m_pos = 0; m_ss = 1; m_sel = ratio_sel;
      m_j = spread_en ? int'(m_lfsr[1:0]) : 0;
    end else begin
      m_ss = 0;
      if (m_pos == n + m_j - 1) begin
        m_pos = 0; m_cnt = m_cnt + 16'd1; m_corr = 1;
        m_lfsr = adv(m_lfsr);
        m_j = spread_en ? int'(m_lfsr[1:0]) : 0;
        m_sel = ratio_sel;
      end else m_pos++;
    end
  endtask

  task automatic compare();
    int n, h, q, hv, c;
    bit e_mode, e_v, e_vlo, e_dlt;
    n = 8 << m_sel; h = n / 2; q = n / 8; hv = h + m_j; c = m_pos - hv;
    e_mode = m_act && m_pos >= hv;
    e_v    = m_act && m_pos < hv && m_pos >= hv - q;
    e_vlo  = e_mode && c >= h - q - 1 && c <= h - 2;
    e_dlt  = e_mode && c == h - 1;
    chk(mode_cur == e_mode, "R2 mode_cur", mode_cur, e_mode);
    chk(trk_vhi == e_v && trk_iout == e_v, "R3 trk_vhi/trk_iout", {trk_vhi, trk_iout}, {e_v, e_v});
    chk(trk_vlo == e_vlo, "R4 trk_vlo", trk_vlo, e_vlo);
    chk(trk_dlt == e_dlt, "R4 trk_dlt", trk_dlt, e_dlt);
    chk(corr_en == m_corr, "R5 corr_en", corr_en, m_corr);
    chk(ss_start == m_ss, "R8 ss_start", ss_start, m_ss);
    chk(cycle_cnt == m_cnt, "R11 cycle_cnt", cycle_cnt, m_cnt);
  endtask

  task automatic clk_step();
    model_next();
    @(negedge clk);
    compare();
  endtask

  task automatic steps(input int k);
    for (int i = 0; i < k; i++) clk_step();
  endtask

  task automatic start(input logic [2:0] sel, input bit spr);
    run = 0; ovp = 0; clk_step();
    ratio_sel = sel; spread_en = spr; run = 1;
    clk_step();
  endtask

  task automatic cycle_len(output int len);
    logic [15:0] c0;
    c0 = cycle_cnt; len = 0;
    while (cycle_cnt == c0) begin clk_step(); len++; end
  endtask

  task automatic t_reset();
    chk(!mode_cur && !trk_vhi && !trk_vlo && !trk_dlt && !corr_en && !ss_start,
        "R7 reset outputs idle", {mode_cur, trk_vhi, trk_vlo, trk_dlt, corr_en, ss_start}, 0);
    chk(cycle_cnt == 0, "R7 reset cycle_cnt", cycle_cnt, 0);
  endtask

  task automatic t_sync();
    @(negedge clk); #1;
    chk(sync_out == clk, "R12 sync low phase", sync_out, clk);
    @(posedge clk); #1;
    chk(sync_out == 1'b1, "R12 sync high phase", sync_out, 1);
    @(negedge clk);
  endtask

  task automatic t_ratio_table();
    int len;
    for (int s = 0; s < 8; s++) begin
      start(3'(s), 0);
      cycle_len(len);
      chk(len == (8 << s), "R1 cycle length", len, 8 << s);
    end
  endtask

  task automatic t_phase_positions();
    start(3'd0, 0);
    // pos 0..7 of an 8-clock cycle
    for (int p = 0; p < 8; p++) begin
      chk(mode_cur == (p >= 4), "R2 mode at position", mode_cur, p >= 4);
      chk(trk_vhi == (p == 3) && trk_iout == (p == 3), "R3 strobe at position", trk_vhi, p == 3);
      chk(trk_vlo == (p == 6), "R4 vlo at position", trk_vlo, p == 6);
      chk(trk_dlt == (p == 7), "R4 dlt at position", trk_dlt, p == 7);
      clk_step();
    end
  endtask

  task automatic t_corr_first_cycle();
    int len;
    start(3'd1, 0);
    chk(ss_start == 1 && corr_en == 0, "R5 no correction at start", corr_en, 0);
    cycle_len(len);
    chk(corr_en == 1, "R5 correction after first cycle", corr_en, 1);
  endtask

  task automatic t_spread();
    int len;
    bit diff = 0;
    start(3'd0, 1);
    cycle_len(len);
    chk(len == 9, "R6 first spread cycle uses seed bits", len, 9);
    for (int i = 0; i < 24; i++) begin
      cycle_len(len);
      chk(len >= 8 && len <= 11, "R6 spread length bound", len, 8);
      if (len != 8) diff = 1;
    end
    chk(diff, "R6 spread changes length", diff, 1);
    spread_en = 0;
    cycle_len(len);
    cycle_len(len);
    chk(len == 8, "R6 spread off periodic", len, 8);
  endtask

  task automatic t_ratio_change();
    int len;
    start(3'd1, 0);
    steps(5);
    ratio_sel = 3'd3;
    cycle_len(len);
    chk(len == 11, "R10 current cycle keeps old ratio", len, 11);
    cycle_len(len);
    chk(len == 64, "R10 next cycle uses new ratio", len, 64);
  endtask

  task automatic t_ovp();
    start(3'd2, 0);
    steps(40);
    ovp = 1;
    clk_step();
    chk(!mode_cur && !corr_en && !trk_vhi && !trk_vlo && !trk_dlt, "R9 overvoltage quiets outputs",
        {mode_cur, corr_en}, 0);
    steps(10);
    chk(cycle_cnt == 0 && !corr_en, "R9 held during overvoltage", cycle_cnt, 0);
    ovp = 0;
    clk_step();
    chk(ss_start == 1, "R8 restart pulse after overvoltage", ss_start, 1);
    chk(corr_en == 0, "R5 correction restarts from zero", corr_en, 1'b0);
    clk_step();
    chk(ss_start == 0, "R8 pulse lasts one clock", ss_start, 0);
  endtask

  task automatic t_run_drop();
    start(3'd0, 0);
    steps(20);
    run = 0;
    clk_step();
    chk(cycle_cnt == 0 && !mode_cur && !corr_en, "R7 run low clears state", cycle_cnt, 0);
    ratio_sel = 3'd5; spread_en = 1;
    steps(12);
    chk(!trk_vhi && !trk_vlo && !trk_dlt && !ss_start && cycle_cnt == 0,
        "R7 inputs ignored while idle", {trk_vhi, trk_vlo, trk_dlt, ss_start}, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    steps(4);
    rst_n = 1;
    steps(2);
    t_reset();
    t_sync();
    t_ratio_table();
    t_phase_positions();
    t_corr_first_cycle();
    t_spread();
    t_ratio_change();
    t_ovp();
    t_run_drop();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule